// File: doc/BRIEF.md
# Two-Way Latch/Register Bus Transceiver

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction has its own storage element, its own latch-enable and strobe inputs, and its own output enable. Every direction selects one of three behaviours each system-clock cycle. With latch enable high, the storage element is transparent: it reloads from its source port on every cycle. With latch enable low and a steady strobe, it holds its value. With latch enable low and a high-to-low strobe transition, it captures the source port.

The whole block runs on one fast system clock. The strobes are ordinary sampled inputs, and a falling edge is recognised when the registered previous sample is 1 and the current sample is 0. Each port is presented as a data bus plus a drive-enable bit, for use by pad logic elsewhere. The A-to-B enable is active high and the B-to-A enable is active low. Storage and drive enables are registered, so every output reflects its inputs one system-clock cycle later.

Top module: `ubt_xcvr`

## Requirements
- R1: Both directions carry a full 18-bit word and operate independently, so each port can carry a different value in the same cycle.
- R2: While le_ab is 1, b_out equals the a_in value of the previous system-clock cycle.
- R3: While le_ab is 0 and stb_ab keeps its level, b_out does not change, whatever a_in does.
- R4: While le_ab is 0, in the cycle where stb_ab is sampled 0 after having been sampled 1, the a_in value of that cycle is stored and appears on b_out in the next cycle.
- R5: A low-to-high transition of stb_ab with le_ab at 0 stores nothing.
- R6: When le_ab goes from 1 to 0 with stb_ab low, b_out keeps the a_in value from the last cycle in which le_ab was 1.
- R7: b_drv equals the previous cycle's oe_ab (active high) and is 0 whenever oe_ab was 0, regardless of the stored data.
- R8: a_drv equals the inverse of the previous cycle's oe_ba_n (active low).
- R9: The B-to-A direction follows R2 to R6 with le_ba, stb_ba, b_in and a_out.
- R10: While rst_n is 0, both stored words are 0 and both drive-enable bits are 0. The stored words stay 0 after release until they are loaded.
- R11: With both directions enabled, each storage element loads only from its own source input. A capture in one direction leaves the other direction's output unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in | input | 18 | Word arriving on port A |
| le_ab | input | 1 | A-to-B latch enable (1 = transparent) |
| stb_ab | input | 1 | A-to-B capture strobe, falling edge active |
| oe_ab | input | 1 | A-to-B output enable, active high |
| b_in | input | 18 | Word arriving on port B |
| le_ba | input | 1 | B-to-A latch enable (1 = transparent) |
| stb_ba | input | 1 | B-to-A capture strobe, falling edge active |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| b_out | output | 18 | Word presented on port B |
| b_drv | output | 1 | Port B drive enable |
| a_out | output | 18 | Word presented on port A |
| a_drv | output | 1 | Port A drive enable |

## Verification
The bench builds the block with its default width of 18. Distinct patterns per direction therefore show at once that neither word leaks into the other and that every bit reaches the far port. One pass through the table drives both directions through transparent, hold after a latch-enable fall, steady-strobe hold, rising-strobe non-capture and falling-strobe capture. It also toggles the enables of opposite polarity while data is held. Directed steps then assert reset in the middle of a run to reach the cleared state.

// File: rtl/ubt_pkg.sv
package ubt_pkg;
  typedef enum logic [1:0] {
    MODE_PASS    = 2'd0,
    MODE_HOLD    = 2'd1,
    MODE_CAPTURE = 2'd2
  } ubt_mode_e;
endpackage

// File: rtl/ubt_fall_det.sv
module ubt_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic fall_o
);
  logic stb_q;
  logic stb_d;

  always_comb begin
    stb_d = stb_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_d;
  end

  assign fall_o = stb_q & ~stb_i;
endmodule

// File: rtl/ubt_store.sv
module ubt_store
  import ubt_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_i,
  input  logic             le_i,
  input  logic             fall_i,
  output logic [WIDTH-1:0] q_o
);
  ubt_mode_e        mode;
  logic             load_en;
  logic [WIDTH-1:0] q_d;
  logic [WIDTH-1:0] q_r;

  always_comb begin
    if (le_i)        mode = MODE_PASS;
    else if (fall_i) mode = MODE_CAPTURE;
    else             mode = MODE_HOLD;
  end

  always_comb begin
    load_en = 1'b0;
    q_d     = q_r;
    unique case (mode)
      MODE_PASS, MODE_CAPTURE: begin
        load_en = 1'b1;
        q_d     = src_i;
      end
      default: begin
        load_en = 1'b0;
        q_d     = q_r;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_r <= '0;
    else if (load_en) q_r <= q_d;
  end

  assign q_o = q_r;

  // R2
  pass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    le_i |=> (q_o == $past(src_i)));

  // R3
  steady_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && !fall_i) |=> $stable(q_o));

  // R4
  fall_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_i && fall_i) |=> (q_o == $past(src_i)));
endmodule

// File: rtl/ubt_lane.sv
module ubt_lane #(
  parameter int WIDTH  = 18,
  parameter bit OE_LOW = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] src_i,
  input  logic             le_i,
  input  logic             stb_i,
  input  logic             oe_i,
  output logic [WIDTH-1:0] q_o,
  output logic             drv_o
);
  logic fall;
  logic oe_act;
  logic drv_d;
  logic drv_q;

  ubt_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .stb_i  (stb_i),
    .fall_o (fall)
  );

  ubt_store #(.WIDTH(WIDTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (src_i),
    .le_i   (le_i),
    .fall_i (fall),
    .q_o    (q_o)
  );

  generate
    if (OE_LOW) begin : g_oe_low
      assign oe_act = ~oe_i;
    end else begin : g_oe_high
      assign oe_act = oe_i;
    end
  endgenerate

  always_comb begin
    drv_d = oe_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= 1'b0;
    else        drv_q <= drv_d;
  end

  assign drv_o = drv_q;
endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] a_in,
  input  logic             le_ab,
  input  logic             stb_ab,
  input  logic             oe_ab,
  input  logic [WIDTH-1:0] b_in,
  input  logic             le_ba,
  input  logic             stb_ba,
  input  logic             oe_ba_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drv,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drv
);
  ubt_lane #(.WIDTH(WIDTH), .OE_LOW(1'b0)) u_ab (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (a_in),
    .le_i  (le_ab),
    .stb_i (stb_ab),
    .oe_i  (oe_ab),
    .q_o   (b_out),
    .drv_o (b_drv)
  );

  ubt_lane #(.WIDTH(WIDTH), .OE_LOW(1'b1)) u_ba (
    .clk   (clk),
    .rst_n (rst_n),
    .src_i (b_in),
    .le_i  (le_ba),
    .stb_i (stb_ba),
    .oe_i  (oe_ba_n),
    .q_o   (a_out),
    .drv_o (a_drv)
  );

  // R7
  b_drive_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_ab |=> !b_drv);

  // R8
  a_drive_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_ba_n |=> !a_drv);

  // R11
  ba_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_ba && $stable(stb_ba)) |=> $stable(a_out));
endmodule

// File: tb/ubt_xcvr_bench.sv
module ubt_xcvr_bench;
  localparam int W = 18;

  typedef struct packed {
    logic [W-1:0] a;
    logic         leab;
    logic         stbab;
    logic         oeab;
    logic [W-1:0] b;
    logic         leba;
    logic         stbba;
    logic         oebn;
    logic [W-1:0] eb;
    logic         ebd;
    logic [W-1:0] ea;
    logic         ead;
    logic [3:0]   req;
  } vec_t;

  localparam int NV = 13;
  // Per-row tags: R1/R2/R9, R2, R6, R3, R5, R4, R3, R7/R8, R5, R4/R9, R11, R11, R11
  localparam vec_t VECS [NV] = '{
    '{18'h11111,1'b1,1'b0,1'b1, 18'h22222,1'b1,1'b0,1'b0, 18'h11111,1'b1, 18'h22222,1'b1, 4'd1},
    '{18'h0ABCD,1'b1,1'b0,1'b1, 18'h13579,1'b1,1'b0,1'b0, 18'h0ABCD,1'b1, 18'h13579,1'b1, 4'd2},
    '{18'h3FFFF,1'b0,1'b0,1'b1, 18'h00001,1'b0,1'b0,1'b0, 18'h0ABCD,1'b1, 18'h13579,1'b1, 4'd6},
    '{18'h15555,1'b0,1'b0,1'b1, 18'h2AAAA,1'b0,1'b0,1'b0, 18'h0ABCD,1'b1, 18'h13579,1'b1, 4'd3},
    '{18'h00F0F,1'b0,1'b1,1'b1, 18'h3C3C3,1'b0,1'b1,1'b0, 18'h0ABCD,1'b1, 18'h13579,1'b1, 4'd5},
    '{18'h12345,1'b0,1'b0,1'b1, 18'h06789,1'b0,1'b0,1'b0, 18'h12345,1'b1, 18'h06789,1'b1, 4'd4},
    '{18'h00000,1'b0,1'b0,1'b1, 18'h00000,1'b0,1'b0,1'b0, 18'h12345,1'b1, 18'h06789,1'b1, 4'd3},
    '{18'h00000,1'b0,1'b0,1'b0, 18'h00000,1'b0,1'b0,1'b1, 18'h12345,1'b0, 18'h06789,1'b0, 4'd7},
    '{18'h2468A,1'b0,1'b1,1'b0, 18'h00000,1'b0,1'b0,1'b1, 18'h12345,1'b0, 18'h06789,1'b0, 4'd5},
    '{18'h2468A,1'b0,1'b0,1'b0, 18'h1ACE0,1'b1,1'b0,1'b1, 18'h2468A,1'b0, 18'h1ACE0,1'b0, 4'd9},
    '{18'h3F00F,1'b1,1'b0,1'b1, 18'h00FF0,1'b1,1'b0,1'b0, 18'h3F00F,1'b1, 18'h00FF0,1'b1, 4'd11},
    '{18'h11111,1'b0,1'b1,1'b1, 18'h2BEEF,1'b1,1'b0,1'b0, 18'h3F00F,1'b1, 18'h2BEEF,1'b1, 4'd11},
    '{18'h0F0F0,1'b0,1'b0,1'b1, 18'h2BEEF,1'b1,1'b0,1'b0, 18'h0F0F0,1'b1, 18'h2BEEF,1'b1, 4'd11}
  };

  logic         clk;
  logic         rst_n;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic         le_ab, stb_ab, oe_ab, le_ba, stb_ba, oe_ba_n;
  logic         a_drv, b_drv;
  int           n_chk;
  int           n_bad;
  bit           done;

  ubt_xcvr #(.WIDTH(W)) u_ubt_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .le_ab(le_ab), .stb_ab(stb_ab), .oe_ab(oe_ab),
    .b_in(b_in), .le_ba(le_ba), .stb_ba(stb_ba), .oe_ba_n(oe_ba_n),
    .b_out(b_out), .b_drv(b_drv), .a_out(a_out), .a_drv(a_drv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    a_in = '0; b_in = '0; le_ab = 1'b0; stb_ab = 1'b0; oe_ab = 1'b0;
    le_ba = 1'b0; stb_ba = 1'b0; oe_ba_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R10 reset state
    chk("R10", "b_out", b_out, '0);
    chk("R10", "a_out", a_out, '0);
    chk("R10", "b_drv", {17'd0, b_drv}, '0);
    chk("R10", "a_drv", {17'd0, a_drv}, '0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      @(negedge clk);
      a_in = VECS[i].a; le_ab = VECS[i].leab; stb_ab = VECS[i].stbab; oe_ab = VECS[i].oeab;
      b_in = VECS[i].b; le_ba = VECS[i].leba; stb_ba = VECS[i].stbba; oe_ba_n = VECS[i].oebn;
      @(posedge clk); #1;
      rq = $sformatf("R%0d", VECS[i].req);
      chk(rq, "b_out", b_out, VECS[i].eb);
      chk(rq, "b_drv", {17'd0, b_drv}, {17'd0, VECS[i].ebd});
      chk(rq, "a_out", a_out, VECS[i].ea);
      chk(rq, "a_drv", {17'd0, a_drv}, {17'd0, VECS[i].ead});
    end

    // R10 reset in the middle of a run clears data and drive enables
    @(negedge clk);
    le_ab = 1'b0; stb_ab = 1'b0; oe_ab = 1'b0;
    le_ba = 1'b0; stb_ba = 1'b0; oe_ba_n = 1'b1;
    rst_n = 1'b0;
    #1;
    chk("R10", "b_out in reset", b_out, '0);
    chk("R10", "a_out in reset", a_out, '0);
    chk("R10", "b_drv in reset", {17'd0, b_drv}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    a_in = 18'h3FFFF; b_in = 18'h3FFFF;
    repeat (2) @(posedge clk);
    #1;
    chk("R10", "b_out after release", b_out, '0);
    chk("R10", "a_out after release", a_out, '0);

    // R8 active-low enable on its own
    @(negedge clk);
    oe_ba_n = 1'b0;
    @(posedge clk); #1;
    chk("R8", "a_drv", {17'd0, a_drv}, 18'd1);
    chk("R7", "b_drv", {17'd0, b_drv}, 18'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule